// File: doc/BRIEF.md
# DTMF Sample Synthesizer

This block produces the digital transmit waveform of a touch-tone line interface. At a fixed sample rate it outputs a signed sample word, with a one-cycle valid strobe. In dual-tone operation the word is the sum of one low-group sine and one high-group sine. In single-tone operation it is one sine on its own. A 4-bit tone code selects the frequencies and a 3-bit mode selects the kind of operation. A squelch bit and a 4-bit attenuation code, in 1 dB steps, set the level. The block runs from a 3.579545 MHz reference clock. It divides that clock down to the sample strobe, so no other timing source is needed.

Each tone comes from its own phase accumulator, which addresses a quarter-wave sine table computed at elaboration. The high-group tone carries a fixed gain about 1 dB above the low group. A single multiply applies the attenuation just ahead of the output register. The accumulators run continuously, so the phase stays continuous when the code or the mode changes. Reconstruction filtering, conversion to analog and line driving are done by the circuits that follow this block.

Top module: `dtmf_synth`

## Requirements
- R1: `sample_valid` is high for exactly one clock every DIV = CLK_HZ / SAMPLE_HZ (integer division) clocks. The first pulse comes DIV clocks after reset is released. `sample` holds its value between pulses.
- R2: While reset is asserted, `sample` is 0 and `sample_valid` is 0.
- R3: Dual-tone pairs (low + high, in Hz) by tone code:
  - 697 Hz with 1209 / 1336 / 1477 / 1633 at codes 1 / 2 / 3 / 13.
  - 770 Hz with 1209 / 1336 / 1477 / 1633 at codes 4 / 5 / 6 / 14.
  - 852 Hz with 1209 / 1336 / 1477 / 1633 at codes 7 / 8 / 9 / 15.
  - 941 Hz with 1209 / 1336 / 1477 / 1633 at codes 11 / 10 / 12 / 0.
- R4: Single-tone frequency by code:
  - 697 Hz for codes 1 to 3.
  - 770 Hz for codes 4 to 6.
  - 852 Hz for code 7.
  - 941 Hz for code 0.
  - 1209 Hz for code 11.
  - 1336 Hz for codes 8 and 10.
  - 1477 Hz for codes 9 and 12.
  - 1633 Hz for codes 13 to 15.
- R5: Both phases start at 0 after reset and advance on every strobe edge, whatever the mode, squelch or attenuation.
  - Increment per strobe: round(f·2^24·DIV/CLK_HZ).
  - Tone A uses the single-tone frequency in single-tone mode and the low-group frequency otherwise. Tone B uses the high-group frequency.
  - Each strobe emits the value for the phases held before that advance.
  - The emitted value is within 120 LSB of g·(a_A·sin(2π·φA/2^24) + a_B·sin(2π·φB/2^24)).
- R6: Tone levels:
  - Low-group amplitude is 12478 and high-group amplitude is 14000, so the high group is 1.0 dB louder.
  - In single-tone mode only tone A sounds. Its amplitude is 14000 for frequencies of 1209 Hz and above, and 12478 otherwise.
- R7: Attenuation code N (0 to 15) sets g = 10^(−N/20), which is N dB of attenuation.
- R8: With `squelch` = 1, every emitted sample is exactly 0 in all modes.
- R9: Mode encoding: 3'b001 is dual-tone transmit, 3'b010 is single-tone, and 3'b101 is loopback, which sounds dual tone. Codes 3'b000, 3'b011, 3'b100, 3'b110 and 3'b111 emit exactly 0.
- R10: Every synthesized frequency, measured by zero crossings of the sample stream, is within 1% of its nominal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_code | input | 4 | Tone selection code |
| mode | input | 3 | Function mode |
| squelch | input | 1 | Forces output to zero when 1 |
| atten | input | 4 | Attenuation in dB |
| sample | output | OUT_W (16) | Signed output sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The accumulators are never cleared, so a wrong increment or a wrong code decode drifts the phase away from the model on every strobe. After that the mismatch shows on every following sample, usually within a few strobes of the code change. An error in the table, the amplitude or the gain shows on the first non-zero sample of an affected setting. A gating error shows as a non-zero word in a silent mode at the very next strobe. A divider error moves the strobe spacing and is caught at the first pulse after reset.

// File: rtl/dtmf_synth.sv
module dtmf_synth #(
  parameter int CLK_HZ    = 3579545,
  parameter int SAMPLE_HZ = 8000,
  parameter int PH_W      = 24,
  parameter int LUT_AW    = 8,
  parameter int OUT_W     = 16,
  parameter int LO_AMP    = 12478,
  parameter int HI_AMP    = 14000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              tone_code,
  input  logic [2:0]              mode,
  input  logic                    squelch,
  input  logic [3:0]              atten,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);

  localparam int DIV   = CLK_HZ / SAMPLE_HZ;
  localparam int CNT_W = $clog2(DIV);
  localparam int QN    = 1 << LUT_AW;
  localparam int FREQ [8] = '{697, 770, 852, 941, 1209, 1336, 1477, 1633};
  localparam logic [2:0] MODE_TX = 3'b001;
  localparam logic [2:0] MODE_ST = 3'b010;
  localparam logic [2:0] MODE_LB = 3'b101;
  localparam logic signed [15:0] LO_A = 16'(LO_AMP);
  localparam logic signed [15:0] HI_A = 16'(HI_AMP);

  function automatic int qsin(input int i);
    real x, t, s;
    x = (real'(i) + 0.5) * 3.14159265358979 / (2.0 * real'(QN));
    s = x;
    t = x;
    for (int k = 1; k < 8; k++) begin
      t = -t * x * x / real'((2 * k) * (2 * k + 1));
      s = s + t;
    end
    return $rtoi(s * 32767.0 + 0.5);
  endfunction

  function automatic int gain_q(input int n);
    real g;
    g = 1.0;
    for (int i = 0; i < n; i++) g = g / 1.12201845430196;
    return $rtoi(32767.0 * g + 0.5);
  endfunction

  function automatic logic [PH_W-1:0] calc_inc(input int f);
    longint num;
    num = (longint'(f) << PH_W) * longint'(DIV) + longint'(CLK_HZ / 2);
    return PH_W'(num / longint'(CLK_HZ));
  endfunction

  logic [14:0]        qlut   [QN];
  logic signed [15:0] gtab   [16];
  logic [PH_W-1:0]    inc_tab[8];

  for (genvar g = 0; g < QN; g++) begin : g_lut
    assign qlut[g] = 15'(qsin(g));
  end
  for (genvar g = 0; g < 16; g++) begin : g_gain
    assign gtab[g] = 16'(gain_q(g));
  end
  for (genvar g = 0; g < 8; g++) begin : g_inc
    assign inc_tab[g] = calc_inc(FREQ[g]);
  end

  function automatic logic signed [16:0] wave(input logic [PH_W-1:0] ph);
    logic [1:0]        q;
    logic [LUT_AW-1:0] idx;
    logic signed [16:0] m;
    q   = ph[PH_W-1 -: 2];
    idx = ph[PH_W-3 -: LUT_AW];
    m   = q[0] ? 17'(qlut[~idx]) : 17'(qlut[idx]);
    return q[1] ? -m : m;
  endfunction

  logic [2:0] lo_k, hi_k, st_k;
  always_comb begin
    case (tone_code)
      4'h1:    begin lo_k = 3'd0; hi_k = 3'd4; st_k = 3'd0; end
      4'h2:    begin lo_k = 3'd0; hi_k = 3'd5; st_k = 3'd0; end
      4'h3:    begin lo_k = 3'd0; hi_k = 3'd6; st_k = 3'd0; end
      4'h4:    begin lo_k = 3'd1; hi_k = 3'd4; st_k = 3'd1; end
      4'h5:    begin lo_k = 3'd1; hi_k = 3'd5; st_k = 3'd1; end
      4'h6:    begin lo_k = 3'd1; hi_k = 3'd6; st_k = 3'd1; end
      4'h7:    begin lo_k = 3'd2; hi_k = 3'd4; st_k = 3'd2; end
      4'h8:    begin lo_k = 3'd2; hi_k = 3'd5; st_k = 3'd5; end
      4'h9:    begin lo_k = 3'd2; hi_k = 3'd6; st_k = 3'd6; end
      4'hA:    begin lo_k = 3'd3; hi_k = 3'd5; st_k = 3'd5; end
      4'hB:    begin lo_k = 3'd3; hi_k = 3'd4; st_k = 3'd4; end
      4'hC:    begin lo_k = 3'd3; hi_k = 3'd6; st_k = 3'd6; end
      4'hD:    begin lo_k = 3'd0; hi_k = 3'd7; st_k = 3'd7; end
      4'hE:    begin lo_k = 3'd1; hi_k = 3'd7; st_k = 3'd7; end
      4'hF:    begin lo_k = 3'd2; hi_k = 3'd7; st_k = 3'd7; end
      default: begin lo_k = 3'd3; hi_k = 3'd7; st_k = 3'd3; end
    endcase
  end

  wire dual_on   = (mode == MODE_TX) || (mode == MODE_LB);
  wire single_on = (mode == MODE_ST);
  wire tone_on   = (dual_on || single_on) && !squelch;

  logic [CNT_W-1:0] cnt;
  wire tick = (cnt == CNT_W'(DIV - 1));

  logic [PH_W-1:0] acc_a, acc_b;
  wire [PH_W-1:0] inc_a = single_on ? inc_tab[st_k] : inc_tab[lo_k];

  wire signed [15:0] amp_a  = (single_on && st_k[2]) ? HI_A : LO_A;
  wire signed [16:0] wa     = wave(acc_a);
  wire signed [16:0] wb     = wave(acc_b);
  wire signed [32:0] prod_a = wa * amp_a;
  wire signed [32:0] prod_b = wb * HI_A;
  wire signed [17:0] mix    = 18'(prod_a >>> 15) + (dual_on ? 18'(prod_b >>> 15) : 18'sd0);
  wire signed [33:0] prod_g = mix * gtab[atten];
  wire signed [OUT_W-1:0] shaped = tone_on ? OUT_W'(prod_g >>> 15) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      acc_a        <= '0;
      acc_b        <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      cnt          <= tick ? '0 : cnt + 1'b1;
      sample_valid <= tick;
      if (tick) begin
        sample <= shaped;
        acc_a  <= acc_a + inc_a;
        acc_b  <= acc_b + inc_tab[hi_k];
      end
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R1
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample));

  // R8
  silent_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !$past(tone_on)) |-> (sample == '0));

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(acc_a) && $stable(acc_b)));

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample <= OUT_W'(LO_AMP + HI_AMP)) && (sample >= -OUT_W'(LO_AMP + HI_AMP)));

endmodule

// File: tb/dtmf_synth_bench.sv
module dtmf_synth_bench;
  localparam int CLK_HZ = 64000, SAMPLE_HZ = 8000, DIV = CLK_HZ / SAMPLE_HZ;
  localparam int LO_AMP = 12478, HI_AMP = 14000, TOL = 120;
  localparam real PI = 3.14159265358979;
  localparam longint PH_MOD = 64'd1 << 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [3:0]        tone_code;
  logic [2:0]        mode;
  logic              squelch;
  logic [3:0]        atten;
  logic signed [15:0] sample;
  logic              sample_valid;

  dtmf_synth #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ)) u_dtmf_synth (
    .clk(clk), .rst_n(rst_n), .tone_code(tone_code), .mode(mode),
    .squelch(squelch), .atten(atten), .sample(sample), .sample_valid(sample_valid));

  int checks = 0, fails = 0;
  longint pa = 0, pb = 0;
  int gap = 0;
  string tag = "R2";
  bit zc_on = 0, have_prev = 0;
  int zc = 0, prev_s = 0;

  function automatic int lo_hz(input logic [3:0] c);
    case (c)
      1, 2, 3, 13: return 697;
      4, 5, 6, 14: return 770;
      7, 8, 9, 15: return 852;
      default:     return 941;
    endcase
  endfunction

  function automatic int hi_hz(input logic [3:0] c);
    case (c)
      1, 4, 7, 11: return 1209;
      2, 5, 8, 10: return 1336;
      3, 6, 9, 12: return 1477;
      default:     return 1633;
    endcase
  endfunction

  function automatic int st_hz(input logic [3:0] c);
    case (c)
      1, 2, 3:     return 697;
      4, 5, 6:     return 770;
      7:           return 852;
      0:           return 941;
      11:          return 1209;
      8, 10:       return 1336;
      9, 12:       return 1477;
      default:     return 1633;
    endcase
  endfunction

  function automatic longint inc_of(input int f);
    return ((longint'(f) << 24) * DIV + CLK_HZ / 2) / CLK_HZ;
  endfunction

  task automatic check(input bit ok, input string t, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0f expected %0f", t, act, exp);
    end
  endtask

  task automatic step();
    bit dual, single, active;
    int fa;
    real v;
    @(negedge clk);
    gap++;
    if (sample_valid) begin
      check(gap == DIV, "R1", gap, DIV);
      gap    = 0;
      dual   = (mode == 3'b001) || (mode == 3'b101);
      single = (mode == 3'b010);
      active = (dual || single) && !squelch;
      fa     = single ? st_hz(tone_code) : lo_hz(tone_code);
      if (!active) begin
        check(sample == 0, tag, sample, 0.0);
      end else begin
        v = ((single && fa >= 1209) ? HI_AMP : LO_AMP) * $sin(2.0 * PI * real'(pa) / real'(PH_MOD));
        if (dual) v = v + HI_AMP * $sin(2.0 * PI * real'(pb) / real'(PH_MOD));
        v = v * (10.0 ** (-real'(atten) / 20.0));
        check((real'(sample) - v <= TOL) && (v - real'(sample) <= TOL), tag, sample, v);
      end
      if (zc_on) begin
        if (have_prev && ((prev_s < 0) != (sample < 0))) zc++;
        prev_s = sample;
        have_prev = 1;
      end
      pa = (pa + inc_of(fa)) % PH_MOD;
      pb = (pb + inc_of(hi_hz(tone_code))) % PH_MOD;
    end
  endtask

  task automatic run(input int n);
    int seen = 0;
    while (seen < n) begin
      step();
      if (sample_valid) seen++;
    end
  endtask

  task automatic zc_run(input logic [3:0] c);
    real e;
    tone_code = c;
    zc = 0; have_prev = 0; zc_on = 1;
    run(1600);
    zc_on = 0;
    e = 2.0 * real'(st_hz(c)) * 1600.0 / real'(SAMPLE_HZ);
    check((real'(zc) - e <= e * 0.01 + 1.0) && (e - real'(zc) <= e * 0.01 + 1.0), "R10", zc, e);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; tone_code = 4'h5; mode = 3'b001; squelch = 0; atten = 4'd0;
    // R2: reset state
    repeat (4) begin
      @(negedge clk);
      check(sample == 0 && !sample_valid, "R2", sample, 0.0);
    end
    rst_n = 1;
    gap = 0;
    // R1 and R5: first strobe spacing and phase from zero
    tag = "R5"; run(40);
    // R9: every mode encoding
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m); tag = "R9"; run(100);
    end
    // R3: all dual-tone codes in transmit mode
    mode = 3'b001; tag = "R3";
    for (int c = 0; c < 16; c++) begin
      tone_code = 4'(c); run(120);
    end
    // R4: all single-tone codes
    mode = 3'b010; tag = "R4";
    for (int c = 0; c < 16; c++) begin
      tone_code = 4'(c); run(100);
    end
    // R10: zero-crossing frequency of each single tone
    tag = "R10";
    zc_run(4'h1); zc_run(4'h4); zc_run(4'h7); zc_run(4'h0);
    zc_run(4'hB); zc_run(4'h8); zc_run(4'h9); zc_run(4'hD);
    // R6: group levels in dual and loopback modes
    tag = "R6"; mode = 3'b101; tone_code = 4'h0; run(200);
    // R7: attenuation sweep
    tag = "R7"; mode = 3'b001; tone_code = 4'h5;
    for (int n = 0; n < 16; n++) begin
      atten = 4'(n); run(80);
    end
    atten = 4'd3;
    // R8: squelch in dual and single modes
    tag = "R8"; squelch = 1; mode = 3'b001; run(150);
    mode = 3'b010; run(150);
    squelch = 0;
    // R5: phase continuity across quick code changes
    tag = "R5"; mode = 3'b001; atten = 4'd0;
    for (int k = 0; k < 10; k++) begin
      tone_code = 4'((k * 7) % 16); run(50);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule